// File: doc/BRIEF.md
# CCD Video Sampling Mode Sequencer

This block sequences the sampling of a three-channel (red, green, blue) CCD sensor front end. It runs on the master clock and follows an active-high sync pulse that marks each pixel period. From the sync pulse it produces per-channel sample strobes, the video-level and reset-level strobes used for correlated double sampling (CDS), a channel multiplexer select, and a word strobe, word index and valid flag that describe the output data stream. The analog sample-and-hold, gain stage and converter are not part of the block. The word stream stands in for their output.

Six operating modes are supported. Two are colour modes, in which all channels are sampled together and multiplexed out one after another. Four are monochrome modes, in which one chosen channel is sampled and the multiplexer is held on it. The modes differ in the number of master clocks per sync period (6, 3, 2 or 8), in whether CDS may be used, and in which output words are flagged valid. The mode, the monochrome channel, the reset-sample position and the CDS enable are captured together on each sync pulse. A change on these inputs therefore never disturbs a period that is already running.

Top module: `vsq_top`

## Requirements
- R1: A sync pulse sampled high on a rising clock edge starts a period: in the next cycle `busy_o` is 1, the phase is 0 and the channel sample strobes fire. Outputs depend only on registered state and never combinationally on `vsmp_i`.
- R2: The period length in clocks is 6 for modes 1 and 2, 3 for mode 3, 2 for mode 4 and 8 for modes 5 and 6. Mode codes 0 and 7 behave as mode 1. After the last phase with no new pulse, the block goes idle, with `busy_o` = 0 and every strobe, select, index and valid output at 0.
- R3: In colour modes 1 and 5, all three bits of `samp_o` fire at phase 0 (bit 0 red, bit 1 green, bit 2 blue). `mux_sel_o` equals the word index (0 red, 1 green, 2 blue) when that index is below 3, and 0 otherwise.
- R4: In monochrome modes 2, 3, 4 and 6, only the `samp_o` bit of the selected channel fires. `mux_sel_o` stays on that channel for the whole period. `mono_ch_i` = 3 selects red.
- R5: While busy, `word_stb_o` is 1 on odd phases and `word_idx_o` equals the phase shifted right by one. The result is one word every two clocks: 3 per period in the 6-clock modes, 4 in the 8-clock modes and 1 in modes 3 and 4.
- R6: `word_valid_o` is set only with `word_stb_o`. In modes 1 and 5 it is set for word indices 0 to 2. In every other mode it is set for index 0 only.
- R7: With CDS enabled, `vid_smp_o` fires at phase 0 and `rst_smp_o` fires at phase `rst_ref_i`+2. Binary 10 therefore places the reset sample four clocks after the video sample. In mode 3 the reset sample is fixed at phase 1. In mode 4, or with `cds_en_i` = 0, neither CDS strobe fires.
- R8: A pulse that arrives while busy and before the last phase restarts the period at phase 0 and sets `sync_err_o`, which stays set until reset. A pulse at the last phase restarts the period without an error.
- R9: Mode, channel, reset position and CDS enable are captured only on a sync pulse. Changing them during a period has no effect on that period.
- R10: After reset the block is idle with `sync_err_o` = 0, and the captured configuration is mode 1, red channel, reset position 10 and CDS on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsmp_i | input | 1 | Sync pulse, active high, one clock wide |
| mode_i | input | 3 | Operating mode code 1..6 |
| mono_ch_i | input | 2 | Monochrome channel: 0 red, 1 green, 2 blue |
| rst_ref_i | input | 2 | Reset-sample position code |
| cds_en_i | input | 1 | Correlated double sampling enable |
| samp_o | output | 3 | Per-channel sample strobes, bit 0 red |
| vid_smp_o | output | 1 | Video-level sample strobe |
| rst_smp_o | output | 1 | Reset-level sample strobe |
| mux_sel_o | output | 2 | Channel multiplexer select |
| word_stb_o | output | 1 | Output word slot strobe |
| word_idx_o | output | 2 | Index of the word within the period |
| word_valid_o | output | 1 | Current word is valid |
| busy_o | output | 1 | A sampling period is running |
| sync_err_o | output | 1 | Sticky early-sync error |

## Verification
The assertions assume `vsmp_i` is a single-cycle pulse that is synchronous to the master clock. They also assume the configuration inputs are settled whenever that pulse is sampled. The stimulus changes every input on the falling clock edge and holds each pulse for exactly one cycle. Pulses arrive early only in the dedicated error case, and even there they stay one cycle wide. Configuration inputs are deliberately scrambled right after each pulse to show they have no effect within the period.

// File: rtl/vsq_pkg.sv
package vsq_pkg;

    localparam int unsigned CH_N     = 3;
    localparam int unsigned CH_SEL_W = $clog2(CH_N);
    localparam int unsigned PH_W     = 3;
    localparam int unsigned WIDX_W   = PH_W - 1;
    localparam int unsigned WORD_N   = 1 << WIDX_W;
    localparam int unsigned REF_W    = 2;

    typedef enum logic [2:0] {
        MD_COLOUR      = 3'd1,
        MD_MONO        = 3'd2,
        MD_FAST_MONO   = 3'd3,
        MD_BURST_MONO  = 3'd4,
        MD_SLOW_COLOUR = 3'd5,
        MD_SLOW_MONO   = 3'd6
    } vsq_mode_e;

    typedef struct packed {
        vsq_mode_e            mode;
        logic [CH_SEL_W-1:0]  mono;
        logic [REF_W-1:0]     rst_ref;
        logic                 cds;
    } vsq_cfg_t;

    localparam vsq_cfg_t CFG_RESET = '{
        mode:    MD_COLOUR,
        mono:    '0,
        rst_ref: 2'b10,
        cds:     1'b1
    };

    // Unknown codes fall back to the default colour mode.
    function automatic vsq_mode_e norm_mode(input logic [2:0] code);
        vsq_mode_e m;
        case (code)
            3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6: m = vsq_mode_e'(code);
            default:                            m = MD_COLOUR;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vsq_cfg_latch.sv
module vsq_cfg_latch
    import vsq_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                load_i,
    input  logic [2:0]          mode_i,
    input  logic [CH_SEL_W-1:0] mono_i,
    input  logic [REF_W-1:0]    ref_i,
    input  logic                cds_i,
    output vsq_cfg_t            cfg_o
);

    vsq_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load_i) begin
            cfg_d.mode    = norm_mode(mode_i);
            cfg_d.mono    = (int'(mono_i) >= CH_N) ? '0 : mono_i;
            cfg_d.rst_ref = ref_i;
            cfg_d.cds     = cds_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= CFG_RESET;
        else         cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/vsq_mode_decode.sv
module vsq_mode_decode
    import vsq_pkg::*;
(
    input  vsq_cfg_t           cfg_i,
    output logic [PH_W-1:0]    period_m1_o,
    output logic [PH_W-1:0]    rst_pos_o,
    output logic               cds_on_o,
    output logic               colour_o,
    output logic [WORD_N-1:0]  valid_mask_o
);

    localparam logic [PH_W-1:0] PM1_STD   = PH_W'(5);
    localparam logic [PH_W-1:0] PM1_FAST  = PH_W'(2);
    localparam logic [PH_W-1:0] PM1_BURST = PH_W'(1);
    localparam logic [PH_W-1:0] PM1_SLOW  = PH_W'(7);
    localparam logic [PH_W-1:0] FAST_RST  = PH_W'(1);
    localparam logic [WORD_N-1:0] MASK_ALL_CH = WORD_N'((1 << CH_N) - 1);
    localparam logic [WORD_N-1:0] MASK_FIRST  = WORD_N'(1);

    always_comb begin
        period_m1_o  = PM1_STD;
        colour_o     = 1'b0;
        valid_mask_o = MASK_FIRST;
        rst_pos_o    = PH_W'(cfg_i.rst_ref) + PH_W'(2);
        cds_on_o     = cfg_i.cds;
        case (cfg_i.mode)
            MD_COLOUR: begin
                colour_o     = 1'b1;
                valid_mask_o = MASK_ALL_CH;
            end
            MD_MONO: begin
                period_m1_o = PM1_STD;
            end
            MD_FAST_MONO: begin
                period_m1_o = PM1_FAST;
                rst_pos_o   = FAST_RST;
            end
            MD_BURST_MONO: begin
                period_m1_o = PM1_BURST;
                cds_on_o    = 1'b0;
            end
            MD_SLOW_COLOUR: begin
                period_m1_o  = PM1_SLOW;
                colour_o     = 1'b1;
                valid_mask_o = MASK_ALL_CH;
            end
            MD_SLOW_MONO: begin
                period_m1_o = PM1_SLOW;
            end
            default: begin
                colour_o     = 1'b1;
                valid_mask_o = MASK_ALL_CH;
            end
        endcase
    end

endmodule

// File: rtl/vsq_phase_ctl.sv
module vsq_phase_ctl
    import vsq_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             vsmp_i,
    input  logic [PH_W-1:0]  period_m1_i,
    output logic             busy_o,
    output logic [PH_W-1:0]  phase_o,
    output logic             sync_err_o
);

    typedef struct packed {
        logic            busy;
        logic [PH_W-1:0] phase;
        logic            err;
    } ph_state_t;

    ph_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (vsmp_i) begin
            // Restart; an early pulse (before the final phase) is flagged.
            if (st_q.busy && (st_q.phase != period_m1_i)) st_d.err = 1'b1;
            st_d.busy  = 1'b1;
            st_d.phase = '0;
        end else if (st_q.busy) begin
            if (st_q.phase == period_m1_i) begin
                st_d.busy  = 1'b0;
                st_d.phase = '0;
            end else begin
                st_d.phase = st_q.phase + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign busy_o     = st_q.busy;
    assign phase_o    = st_q.phase;
    assign sync_err_o = st_q.err;

endmodule

// File: rtl/vsq_strobe_gen.sv
module vsq_strobe_gen
    import vsq_pkg::*;
(
    input  logic                busy_i,
    input  logic [PH_W-1:0]     phase_i,
    input  logic [CH_SEL_W-1:0] mono_i,
    input  logic                colour_i,
    input  logic                cds_on_i,
    input  logic [PH_W-1:0]     rst_pos_i,
    input  logic [WORD_N-1:0]   valid_mask_i,
    output logic [CH_N-1:0]     samp_o,
    output logic                vid_smp_o,
    output logic                rst_smp_o,
    output logic [CH_SEL_W-1:0] mux_sel_o,
    output logic                word_stb_o,
    output logic [WIDX_W-1:0]   word_idx_o,
    output logic                word_valid_o
);

    logic              at_start;
    logic [WIDX_W-1:0] widx;

    assign at_start = busy_i && (phase_i == '0);
    assign widx     = phase_i[PH_W-1:1];

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        assign samp_o[c] = at_start && (colour_i || (mono_i == CH_SEL_W'(c)));
    end

    always_comb begin
        vid_smp_o    = at_start && cds_on_i;
        rst_smp_o    = busy_i && cds_on_i && (phase_i == rst_pos_i);
        word_stb_o   = busy_i && phase_i[0];
        word_idx_o   = busy_i ? widx : '0;
        word_valid_o = word_stb_o && valid_mask_i[widx];
        mux_sel_o    = '0;
        if (busy_i) begin
            if (!colour_i)            mux_sel_o = mono_i;
            else if (int'(widx) < CH_N) mux_sel_o = CH_SEL_W'(widx);
        end
    end

endmodule

// File: rtl/vsq_top.sv
module vsq_top
    import vsq_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                vsmp_i,
    input  logic [2:0]          mode_i,
    input  logic [CH_SEL_W-1:0] mono_ch_i,
    input  logic [REF_W-1:0]    rst_ref_i,
    input  logic                cds_en_i,
    output logic [CH_N-1:0]     samp_o,
    output logic                vid_smp_o,
    output logic                rst_smp_o,
    output logic [CH_SEL_W-1:0] mux_sel_o,
    output logic                word_stb_o,
    output logic [WIDX_W-1:0]   word_idx_o,
    output logic                word_valid_o,
    output logic                busy_o,
    output logic                sync_err_o
);

    vsq_cfg_t          cfg_q;
    logic [PH_W-1:0]   period_m1;
    logic [PH_W-1:0]   rst_pos;
    logic              cds_on;
    logic              colour;
    logic [WORD_N-1:0] valid_mask;
    logic [PH_W-1:0]   phase;

    vsq_cfg_latch i_cfg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (vsmp_i),
        .mode_i (mode_i),
        .mono_i (mono_ch_i),
        .ref_i  (rst_ref_i),
        .cds_i  (cds_en_i),
        .cfg_o  (cfg_q)
    );

    vsq_mode_decode i_dec (
        .cfg_i        (cfg_q),
        .period_m1_o  (period_m1),
        .rst_pos_o    (rst_pos),
        .cds_on_o     (cds_on),
        .colour_o     (colour),
        .valid_mask_o (valid_mask)
    );

    vsq_phase_ctl i_phase (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .vsmp_i      (vsmp_i),
        .period_m1_i (period_m1),
        .busy_o      (busy_o),
        .phase_o     (phase),
        .sync_err_o  (sync_err_o)
    );

    vsq_strobe_gen i_stb (
        .busy_i       (busy_o),
        .phase_i      (phase),
        .mono_i       (cfg_q.mono),
        .colour_i     (colour),
        .cds_on_i     (cds_on),
        .rst_pos_i    (rst_pos),
        .valid_mask_i (valid_mask),
        .samp_o       (samp_o),
        .vid_smp_o    (vid_smp_o),
        .rst_smp_o    (rst_smp_o),
        .mux_sel_o    (mux_sel_o),
        .word_stb_o   (word_stb_o),
        .word_idx_o   (word_idx_o),
        .word_valid_o (word_valid_o)
    );

endmodule

// File: rtl/vsq_checker.sv
module vsq_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       vsmp_i,
    input logic [2:0] samp_o,
    input logic       vid_smp_o,
    input logic       rst_smp_o,
    input logic [1:0] mux_sel_o,
    input logic       word_stb_o,
    input logic       word_valid_o,
    input logic       busy_o,
    input logic       sync_err_o,
    input logic [2:0] mode_cur
);

    p_start_sample_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vsmp_i |=> (busy_o && (samp_o != 3'b000)));

    p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (samp_o == 3'b000 && !word_stb_o && !vid_smp_o && !rst_smp_o));

    p_samp_shape_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (samp_o != 3'b000) |-> (samp_o == 3'b111 || $countones(samp_o) == 1));

    p_mux_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mux_sel_o != 2'd3);

    p_valid_in_slot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        word_valid_o |-> (word_stb_o && busy_o));

    p_burst_no_cds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_cur == 3'd4) |-> (!vid_smp_o && !rst_smp_o));

    p_cds_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(vid_smp_o && rst_smp_o));

    p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_err_o |=> sync_err_o);

    p_err_needs_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sync_err_o) |-> $past(busy_o && vsmp_i));

endmodule

bind vsq_top vsq_checker i_vsq_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vsmp_i       (vsmp_i),
    .samp_o       (samp_o),
    .vid_smp_o    (vid_smp_o),
    .rst_smp_o    (rst_smp_o),
    .mux_sel_o    (mux_sel_o),
    .word_stb_o   (word_stb_o),
    .word_valid_o (word_valid_o),
    .busy_o       (busy_o),
    .sync_err_o   (sync_err_o),
    .mode_cur     (cfg_q.mode)
);

// File: tb/test_vsq_top.sv
module test_vsq_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vsmp = 1'b0;
    logic [2:0] mode = 3'd1;
    logic [1:0] mono = 2'd0;
    logic [1:0] rref = 2'd2;
    logic       cds = 1'b1;
    logic [2:0] samp;
    logic       vid, rsm, stb, valid, busy, err;
    logic [1:0] mux, idx;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vsq_top i_vsq_top (
        .clk_i(clk), .rst_ni(rst_n), .vsmp_i(vsmp), .mode_i(mode),
        .mono_ch_i(mono), .rst_ref_i(rref), .cds_en_i(cds),
        .samp_o(samp), .vid_smp_o(vid), .rst_smp_o(rsm), .mux_sel_o(mux),
        .word_stb_o(stb), .word_idx_o(idx), .word_valid_o(valid),
        .busy_o(busy), .sync_err_o(err)
    );

    function automatic logic [11:0] obs();
        return {busy, samp, vid, rsm, mux, stb, idx, valid};
    endfunction

    function automatic int period_of(int md);
        int m = (md >= 1 && md <= 6) ? md : 1;
        if (m == 1 || m == 2) return 6;
        if (m == 3) return 3;
        if (m == 4) return 2;
        return 8;
    endfunction

    // Expected outputs in phase ph of a period started with this configuration.
    function automatic logic [11:0] exp_vec(int md, int mc, int rf, int ce, int ph);
        int m = (md >= 1 && md <= 6) ? md : 1;
        int ch = (mc == 3) ? 0 : mc;
        bit colour = (m == 1 || m == 5);
        bit cdson = (ce != 0) && (m != 4);
        int rp = (m == 3) ? 1 : rf + 2;
        int wi = ph / 2;
        logic [2:0] s = '0;
        logic [1:0] mx;
        bit w = (ph % 2) == 1;
        bit v;
        if (ph == 0) s = colour ? 3'b111 : 3'(1 << ch);
        mx = colour ? ((wi < 3) ? 2'(wi) : 2'd0) : 2'(ch);
        v = w && (colour ? (wi < 3) : (wi == 0));
        return {1'b1, s, 1'(cdson && ph == 0), 1'(cdson && ph == rp), mx, 1'(w), 2'(wi), 1'(v)};
    endfunction

    task automatic chk(string tag, logic [11:0] act, logic [11:0] expv);
        nchk++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, expv, $time);
        end
    endtask

    task automatic chk1(string tag, logic act, logic expv);
        nchk++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s act=%b exp=%b t=%0t", tag, act, expv, $time);
        end
    endtask

    // Pulse with the given config; returns at the negedge where phase 0 is visible.
    task automatic pulse(int md, int mc, int rf, int ce);
        mode = 3'(md); mono = 2'(mc); rref = 2'(rf); cds = 1'(ce);
        vsmp = 1'b1;
        @(negedge clk);
        vsmp = 1'b0;
        // Scramble config; must not affect the running period (R9).
        mode = 3'(md ^ 5); mono = 2'(mc + 1); rref = 2'(rf ^ 1); cds = 1'(~ce);
    endtask

    task automatic run_period(int md, int mc, int rf, int ce, string tag);
        int per = period_of(md);
        for (int ph = 0; ph < per; ph++) begin
            if (ph != 0) @(negedge clk);
            chk(tag, obs(), exp_vec(md, mc, rf, ce, ph));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset idle", obs(), 12'h000);
        chk1("R10 reset err", err, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset configuration is colour, CDS on, reset position 10.
        vsmp = 1'b1; @(negedge clk); vsmp = 1'b0;
        chk("R10 default cfg", obs(), exp_vec(1, 0, 2, 1, 0));
        repeat (6) @(negedge clk);

        // Sweep every configuration (R1 R3 R4 R5 R6 R7 R9), then idle (R2).
        for (int md = 0; md < 8; md++)
            for (int mc = 0; mc < 4; mc++)
                for (int rf = 0; rf < 4; rf++)
                    for (int ce = 0; ce < 2; ce++) begin
                        pulse(md, mc, rf, ce);
                        run_period(md, mc, rf, ce, "R1/R3/R4/R5/R6/R7/R9 sweep");
                        @(negedge clk);
                        chk("R2 idle after period", obs(), 12'h000);
                    end
        chk1("R8 no error on spaced pulses", err, 1'b0);

        // Back-to-back pulses at exactly the period, with mode changes between (R8, R2).
        begin
            int seq [5] = '{4, 3, 1, 5, 6};
            for (int k = 0; k < 5; k++) begin
                int md = seq[k];
                int per = period_of(md);
                mode = 3'(md); mono = 2'(k % 3); rref = 2'(k % 4); cds = 1'b1;
                vsmp = 1'b1;
                @(negedge clk);
                vsmp = 1'b0;
                for (int ph = 0; ph < per; ph++) begin
                    if (ph != 0) @(negedge clk);
                    chk("R2 back-to-back period", obs(), exp_vec(md, k % 3, k % 4, 1, ph));
                end
            end
            @(negedge clk);
            chk("R2 idle after chain", obs(), 12'h000);
            chk1("R8 exact ratio no error", err, 1'b0);
        end

        // Early pulse: restart plus sticky error (R8).
        pulse(2, 1, 0, 1);
        @(negedge clk);
        @(negedge clk);
        pulse(5, 2, 3, 1);
        chk("R8 early restart phase 0", obs(), exp_vec(5, 2, 3, 1, 0));
        chk1("R8 error set", err, 1'b1);
        repeat (10) @(negedge clk);
        pulse(4, 0, 0, 0);
        run_period(4, 0, 0, 0, "R8 period after error");
        chk1("R8 error sticky", err, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk1("R10 reset clears error", err, 1'b0);
        chk("R10 reset idle again", obs(), 12'h000);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule